// File: doc/BRIEF.md
# Multicycle Processor Core with Precise Traps

This block is a 32-bit processor core that runs each instruction over several clocks. It supports word load and store, five register-to-register operations (add, subtract, and, or, signed set-less-than), branch-if-equal and an absolute jump. A single memory port is shared between instruction fetch and data access. A single ALU does all the arithmetic, including the PC increment and the branch-target sum. Holding registers keep values from one step to the next: the fetched instruction, the two operands, the ALU result and the loaded word. A state machine whose outputs depend only on its current state puts the steps in order.

The core also detects two faults: an opcode it does not know, and signed overflow on add or subtract. On a fault it records the address of the faulting instruction and a reason code, then jumps to a fixed trap vector. A return instruction later resumes at the recorded address, so the faulting instruction runs again. The saved address and the reason register are brought out as ports. The memory is external and must answer reads combinationally; it takes writes on the rising clock edge while the write strobe is high.

Top module: `seq_core`

## Requirements
- R1: While rst_n is low, the PC is 0, the core is at the start of a fetch (mem_addr = 0), mem_we is low, and the saved-PC and reason registers are 0. All general registers are 0, and register 0 always reads as 0.
- R2: Every instruction takes one fetch clock and then one decode clock. Register operations and stores take 4 clocks in total, loads take 5, and branches, jumps and returns take 3. From reset release, the first store of a program made of load, load, add, store is on mem_we in clock 17, counting from 0.
- R3: A register-format word (opcode bits [31:26] = 0) writes rs op rt into rd. The fields are rs = [25:21], rt = [20:16] and rd = [15:11]. The function field [5:0] selects the operation: 0x20 add, 0x22 subtract, 0x24 and, 0x25 or, 0x2A signed set-less-than (result 1 or 0).
- R4: Opcode 0x23 loads the word at rs + sign-extended [15:0] into rt.
- R5: Opcode 0x2B raises mem_we for exactly one clock, with mem_addr = rs + sign-extended offset and mem_wdata = rt. During fetch, mem_addr carries the PC.
- R6: Opcode 0x04 compares rs and rt. If they are equal, the next PC is PC+4 + (sign-extended offset << 2). Otherwise it is PC+4.
- R7: Opcode 0x02 sets the PC to {PC[31:28], [25:0], 2'b00}.
- R8: A signed overflow on add or subtract leaves rd unchanged. The saved PC is set to the faulting instruction's address, the reason register becomes 12 << 2 (0x30), and the next fetch is from 0x8000_0180.
- R9: An unknown opcode, or a register-format word with an unknown function code or a nonzero bits [10:6], sets the saved PC to that word's address and the reason register to 10 << 2 (0x28), and traps to 0x8000_0180.
- R10: Opcode 0x10 loads the PC from the saved PC, so the faulting instruction runs again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_addr | output | 32 | Byte address of the shared memory: PC during fetch, computed address during data access |
| mem_wdata | output | 32 | Store data |
| mem_we | output | 1 | Store strobe, one clock per store |
| mem_rdata | input | 32 | Combinational read data for mem_addr |
| epc_o | output | 32 | Address of the most recent faulting instruction |
| cause_o | output | 32 | Reason code in bits [6:2] |

## Verification
The bench runs a program whose stores reveal every result. If an operation or its function-code decode were wrong, a stored value would differ. If branches were handled wrongly, a skipped store would appear, or an expected one would go missing, in the scoreboard's order. Overflow is provoked so that a design which still writes rd is exposed by the trap handler's store. A design that saves the incremented PC instead of the faulting one shows up twice: in the saved-PC port, and because the retried add after the return would be skipped. The first-store clock number catches a missing or extra step in the shared fetch and decode prefix.

// File: rtl/seq_core_pkg.sv
// Shared encodings and types for the multicycle core.
// Assumes 32-bit instruction words with fixed field positions.
package seq_core_pkg;

    localparam logic [5:0] OP_REG   = 6'h00;
    localparam logic [5:0] OP_JUMP  = 6'h02;
    localparam logic [5:0] OP_BEQ   = 6'h04;
    localparam logic [5:0] OP_RET   = 6'h10;
    localparam logic [5:0] OP_LOAD  = 6'h23;
    localparam logic [5:0] OP_STORE = 6'h2B;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    localparam logic [4:0] WHY_UNDEF = 5'd10;
    localparam logic [4:0] WHY_OVF   = 5'd12;

    typedef enum logic [3:0] {
        ST_FETCH, ST_DECODE, ST_ADDR, ST_LDMEM, ST_LDWB, ST_STMEM,
        ST_REXE, ST_RWB, ST_BEQ, ST_JMP, ST_TRAP_UND, ST_TRAP_OVF, ST_RET
    } state_e;

    typedef enum logic [2:0] {ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT} alu_fn_e;
    typedef enum logic [1:0] {SB_B, SB_FOUR, SB_IMM, SB_IMM4} srcb_e;
    typedef enum logic [2:0] {PS_ALU, PS_TGT, PS_JMP, PS_EPC, PS_VEC} pcsrc_e;

    typedef struct packed {
        logic       pc_we;
        logic       pc_cond;
        pcsrc_e     pc_src;
        logic       iord;
        logic       mem_we;
        logic       ir_we;
        logic       ab_we;
        logic       s_we;
        logic       m_we;
        logic       rf_we;
        logic       rf_dst_rd;
        logic       rf_from_mem;
        logic       sel_a;
        srcb_e      sel_b;
        logic       use_funct;
        alu_fn_e    alu_fn;
        logic       trap;
        logic [4:0] why;
    } ctrl_t;

    function automatic alu_fn_e funct_fn(input logic [5:0] f);
        case (f)
            FN_SUB:  return ALU_SUB;
            FN_AND:  return ALU_AND;
            FN_OR:   return ALU_OR;
            FN_SLT:  return ALU_SLT;
            default: return ALU_ADD;
        endcase
    endfunction

    function automatic logic funct_known(input logic [5:0] f);
        return (f == FN_ADD) || (f == FN_SUB) || (f == FN_AND) ||
               (f == FN_OR)  || (f == FN_SLT);
    endfunction

endpackage

// File: rtl/seq_core_alu.sv
// Single shared ALU. Reports a zero result and signed overflow; the
// overflow flag is only meaningful for add and subtract, 0 otherwise.
module seq_core_alu
    import seq_core_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_fn_e      fn,
    output logic [W-1:0] y,
    output logic         zero,
    output logic         ovf
);

    // Operation select and overflow detection
    always_comb begin
        ovf = 1'b0;
        case (fn)
            ALU_SUB: begin
                y   = a - b;
                ovf = (a[W-1] != b[W-1]) && (y[W-1] != a[W-1]);
            end
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            default: begin
                y   = a + b;
                ovf = (a[W-1] == b[W-1]) && (y[W-1] != a[W-1]);
            end
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/seq_core_rf.sv
// General register file: two combinational reads, one clocked write.
// Register 0 is never written and so always reads zero.
module seq_core_rf #(
    parameter int W    = 32,
    parameter int NREG = 32,
    localparam int RAW = $clog2(NREG)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [RAW-1:0] ra1,
    input  logic [RAW-1:0] ra2,
    output logic [W-1:0]   rd1,
    output logic [W-1:0]   rd2,
    input  logic           we,
    input  logic [RAW-1:0] wa,
    input  logic [W-1:0]   wd
);

    logic [W-1:0] regs [NREG];

    // Clear on reset, write on enable except to register 0
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we && (wa != '0)) begin
            regs[wa] <= wd;
        end
    end

    assign rd1 = regs[ra1];
    assign rd2 = regs[ra2];

endmodule

// File: rtl/seq_core_ctrl.sv
// Moore control sequencer. Outputs are a function of the state alone;
// the next state uses the opcode, function validity and the ALU overflow.
module seq_core_ctrl
    import seq_core_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [5:0] opcode,
    input  logic       reg_word_ok,
    input  logic       ovf,
    output state_e     state,
    output ctrl_t      ctl
);

    state_e nxt;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_FETCH;
        else        state <= nxt;
    end

    // Next-state function
    always_comb begin
        nxt = ST_FETCH;
        case (state)
            ST_FETCH:  nxt = ST_DECODE;
            ST_DECODE: begin
                case (opcode)
                    OP_REG:   nxt = reg_word_ok ? ST_REXE : ST_TRAP_UND;
                    OP_LOAD,
                    OP_STORE: nxt = ST_ADDR;
                    OP_BEQ:   nxt = ST_BEQ;
                    OP_JUMP:  nxt = ST_JMP;
                    OP_RET:   nxt = ST_RET;
                    default:  nxt = ST_TRAP_UND;
                endcase
            end
            ST_ADDR:   nxt = (opcode == OP_LOAD) ? ST_LDMEM : ST_STMEM;
            ST_LDMEM:  nxt = ST_LDWB;
            ST_REXE:   nxt = ovf ? ST_TRAP_OVF : ST_RWB;
            default:   nxt = ST_FETCH;
        endcase
    end

    // Output function of the current state
    always_comb begin
        ctl = '0;
        case (state)
            ST_FETCH: begin
                ctl.ir_we = 1'b1; ctl.pc_we = 1'b1; ctl.pc_src = PS_ALU;
                ctl.sel_b = SB_FOUR; ctl.alu_fn = ALU_ADD;
            end
            ST_DECODE: begin
                ctl.ab_we = 1'b1; ctl.s_we = 1'b1;
                ctl.sel_b = SB_IMM4; ctl.alu_fn = ALU_ADD;
            end
            ST_ADDR: begin
                ctl.sel_a = 1'b1; ctl.sel_b = SB_IMM; ctl.s_we = 1'b1;
            end
            ST_LDMEM: begin ctl.iord = 1'b1; ctl.m_we = 1'b1; end
            ST_LDWB:  begin ctl.rf_we = 1'b1; ctl.rf_from_mem = 1'b1; end
            ST_STMEM: begin ctl.iord = 1'b1; ctl.mem_we = 1'b1; end
            ST_REXE: begin
                ctl.sel_a = 1'b1; ctl.sel_b = SB_B; ctl.use_funct = 1'b1;
                ctl.s_we = 1'b1;
            end
            ST_RWB: begin ctl.rf_we = 1'b1; ctl.rf_dst_rd = 1'b1; end
            ST_BEQ: begin
                ctl.sel_a = 1'b1; ctl.sel_b = SB_B; ctl.alu_fn = ALU_SUB;
                ctl.pc_cond = 1'b1; ctl.pc_src = PS_TGT;
            end
            ST_JMP: begin ctl.pc_we = 1'b1; ctl.pc_src = PS_JMP; end
            ST_TRAP_UND, ST_TRAP_OVF: begin
                ctl.trap = 1'b1; ctl.pc_we = 1'b1; ctl.pc_src = PS_VEC;
                ctl.sel_b = SB_FOUR; ctl.alu_fn = ALU_SUB;
                ctl.why = (state == ST_TRAP_OVF) ? WHY_OVF : WHY_UNDEF;
            end
            ST_RET: begin ctl.pc_we = 1'b1; ctl.pc_src = PS_EPC; end
            default: ctl = '0;
        endcase
    end

endmodule

// File: rtl/seq_core.sv
// Multicycle core datapath: holding registers, operand muxes, shared
// memory port and trap registers. Assumes a memory that reads
// combinationally and writes on the rising edge while mem_we is high.
module seq_core
    import seq_core_pkg::*;
#(
    parameter int          W        = 32,
    parameter int          NREG     = 32,
    parameter logic [31:0] RESET_PC = 32'h0000_0000,
    parameter logic [31:0] VEC_ADDR = 32'h8000_0180
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] mem_addr,
    output logic [W-1:0] mem_wdata,
    output logic         mem_we,
    input  logic [W-1:0] mem_rdata,
    output logic [W-1:0] epc_o,
    output logic [W-1:0] cause_o
);

    localparam int RAW = $clog2(NREG);

    state_e       state;
    ctrl_t        ctl;
    logic [W-1:0] pc_q, ir_q, a_q, b_q, s_q, m_q, epc_q, cause_q;
    logic [W-1:0] alu_a, alu_b, alu_y, imm_sx, rd1, rd2;
    logic         alu_zero, alu_ovf;
    alu_fn_e      fn;

    assign imm_sx = {{(W-16){ir_q[15]}}, ir_q[15:0]};
    assign alu_a  = ctl.sel_a ? a_q : pc_q;
    assign fn     = ctl.use_funct ? funct_fn(ir_q[5:0]) : ctl.alu_fn;

    // Second ALU operand select
    always_comb begin
        case (ctl.sel_b)
            SB_B:    alu_b = b_q;
            SB_FOUR: alu_b = W'(4);
            SB_IMM:  alu_b = imm_sx;
            default: alu_b = {imm_sx[W-3:0], 2'b00};
        endcase
    end

    seq_core_alu #(.W(W)) u_alu (
        .a(alu_a), .b(alu_b), .fn(fn), .y(alu_y), .zero(alu_zero), .ovf(alu_ovf)
    );

    seq_core_rf #(.W(W), .NREG(NREG)) u_rf (
        .clk(clk), .rst_n(rst_n),
        .ra1(ir_q[21 +: RAW]), .ra2(ir_q[16 +: RAW]),
        .rd1(rd1), .rd2(rd2),
        .we(ctl.rf_we),
        .wa(ctl.rf_dst_rd ? ir_q[11 +: RAW] : ir_q[16 +: RAW]),
        .wd(ctl.rf_from_mem ? m_q : s_q)
    );

    seq_core_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .opcode(ir_q[31:26]),
        .reg_word_ok(funct_known(ir_q[5:0]) && (ir_q[10:6] == 5'd0)),
        .ovf(alu_ovf),
        .state(state), .ctl(ctl)
    );

    // Program counter with unconditional and branch-conditional update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= W'(RESET_PC);
        end else if (ctl.pc_we || (ctl.pc_cond && alu_zero)) begin
            case (ctl.pc_src)
                PS_TGT:  pc_q <= s_q;
                PS_JMP:  pc_q <= {pc_q[W-1:28], ir_q[25:0], 2'b00};
                PS_EPC:  pc_q <= epc_q;
                PS_VEC:  pc_q <= W'(VEC_ADDR);
                default: pc_q <= alu_y;
            endcase
        end
    end

    // Holding registers between steps
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir_q <= '0; a_q <= '0; b_q <= '0; s_q <= '0; m_q <= '0;
        end else begin
            if (ctl.ir_we) ir_q <= mem_rdata;
            if (ctl.ab_we) begin a_q <= rd1; b_q <= rd2; end
            if (ctl.s_we)  s_q  <= alu_y;
            if (ctl.m_we)  m_q  <= mem_rdata;
        end
    end

    // Trap registers: faulting address (PC - 4 through the ALU) and reason
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            epc_q   <= '0;
            cause_q <= '0;
        end else if (ctl.trap) begin
            epc_q   <= alu_y;
            cause_q <= {{(W-7){1'b0}}, ctl.why, 2'b00};
        end
    end

    assign mem_addr  = ctl.iord ? s_q : pc_q;
    assign mem_wdata = b_q;
    assign mem_we    = ctl.mem_we;
    assign epc_o     = epc_q;
    assign cause_o   = cause_q;

endmodule

// File: rtl/seq_core_chk.sv
// Property checker for seq_core, attached by bind below.
module seq_core_chk
    import seq_core_pkg::*;
#(
    parameter int          W        = 32,
    parameter logic [31:0] VEC_ADDR = 32'h8000_0180
) (
    input logic         clk,
    input logic         rst_n,
    input state_e       state,
    input logic [W-1:0] pc,
    input logic [W-1:0] epc,
    input logic [W-1:0] cause,
    input logic         mem_we
);

    a_r2_decode_after_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH) |=> (state == ST_DECODE));

    a_r5_single_store: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    a_r8_vector: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TRAP_OVF || state == ST_TRAP_UND) |=> (pc == W'(VEC_ADDR)));

    a_r8_ovf_reason: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TRAP_OVF) |=> (cause == W'(32'h30)));

    a_r9_reason_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (cause == '0) || (cause == W'(32'h28)) || (cause == W'(32'h30)));

    a_r10_return: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RET) |=> (pc == $past(epc)));

endmodule

bind seq_core seq_core_chk #(.W(W), .VEC_ADDR(VEC_ADDR)) u_chk (
    .clk(clk), .rst_n(rst_n), .state(state), .pc(pc_q),
    .epc(epc_q), .cause(cause_q), .mem_we(mem_we)
);

// File: tb/seq_core_bench.sv
// Scoreboard bench: expected stores are queued up front, a monitor pops
// and compares each store the core makes.
module seq_core_bench;

    typedef struct {
        logic [31:0] addr;
        logic [31:0] data;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata, epc_o, cause_o;
    logic        mem_we;
    logic [31:0] mem [256];
    exp_t        sb_q[$];
    int          n_chk = 0;
    int          n_err = 0;
    int          cyc = 0;
    bit          first_store = 1'b1;

    always #2.5 clk = ~clk;

    seq_core u_seq_core (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_rdata(mem_rdata), .epc_o(epc_o), .cause_o(cause_o)
    );

    assign mem_rdata = mem[mem_addr[9:2]];

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
        cyc <= rst_n ? cyc + 1 : 0;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic expect_store(input logic [31:0] a, input logic [31:0] d, input string tag);
        exp_t e;
        e.addr = a; e.data = d; e.tag = tag;
        sb_q.push_back(e);
    endtask

    function automatic logic [31:0] enc_r(input logic [4:0] rs, input logic [4:0] rt,
                                          input logic [4:0] rd, input logic [5:0] fn);
        return {6'h00, rs, rt, rd, 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs,
                                          input logic [4:0] rt, input logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    // Monitor: compare each store against the head of the scoreboard
    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            if (first_store) begin
                check("R2 first store clock", cyc, 32'd17);
                first_store = 1'b0;
            end
            if (sb_q.size() == 0) begin
                check("R6 unexpected store addr", mem_addr, 32'hFFFF_FFFF);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check({e.tag, " addr"}, mem_addr, e.addr);
                check({e.tag, " data"}, mem_wdata, e.data);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        check("watchdog", 32'd1, 32'd0);
        finish_run();
    end

    // Driver: program, expectations, trap checks
    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
        mem[128] = 32'd7; mem[129] = 32'd5; mem[130] = 32'h7FFF_FFFF;
        mem[131] = 32'd1; mem[132] = 32'd0;
        mem[0]  = enc_i(6'h23, 5'd0, 5'd1, 16'h0200);
        mem[1]  = enc_i(6'h23, 5'd0, 5'd2, 16'h0204);
        mem[2]  = enc_r(5'd1, 5'd2, 5'd3, 6'h20);
        mem[3]  = enc_i(6'h2B, 5'd0, 5'd3, 16'h0240);
        mem[4]  = enc_r(5'd2, 5'd1, 5'd4, 6'h22);
        mem[5]  = enc_i(6'h2B, 5'd0, 5'd4, 16'h0244);
        mem[6]  = enc_r(5'd1, 5'd2, 5'd5, 6'h24);
        mem[7]  = enc_r(5'd1, 5'd2, 5'd6, 6'h25);
        mem[8]  = enc_r(5'd4, 5'd1, 5'd7, 6'h2A);
        mem[9]  = enc_r(5'd1, 5'd2, 5'd8, 6'h2A);
        mem[10] = enc_i(6'h2B, 5'd0, 5'd5, 16'h0248);
        mem[11] = enc_i(6'h2B, 5'd0, 5'd6, 16'h024C);
        mem[12] = enc_i(6'h2B, 5'd0, 5'd7, 16'h0250);
        mem[13] = enc_i(6'h2B, 5'd0, 5'd8, 16'h0254);
        mem[14] = enc_i(6'h04, 5'd1, 5'd2, 16'd5);
        mem[15] = enc_i(6'h2B, 5'd0, 5'd1, 16'h0258);
        mem[16] = enc_i(6'h04, 5'd1, 5'd1, 16'd1);
        mem[17] = enc_i(6'h2B, 5'd0, 5'd2, 16'h025C);
        mem[18] = {6'h02, 26'd20};
        mem[19] = enc_i(6'h2B, 5'd0, 5'd2, 16'h025C);
        mem[20] = enc_i(6'h23, 5'd0, 5'd9, 16'h0208);
        mem[21] = enc_i(6'h23, 5'd0, 5'd10, 16'h020C);
        mem[22] = enc_r(5'd9, 5'd10, 5'd11, 6'h20);
        mem[23] = enc_i(6'h2B, 5'd0, 5'd11, 16'h0264);
        mem[24] = {6'h3F, 26'h0};
        mem[96] = enc_i(6'h2B, 5'd0, 5'd11, 16'h0260);
        mem[97] = enc_i(6'h23, 5'd0, 5'd10, 16'h0210);
        mem[98] = {6'h10, 26'h0};

        expect_store(32'h240, 32'd12,         "R3 R4 R5 add of loaded words");
        expect_store(32'h244, 32'hFFFF_FFFE,  "R3 sub");
        expect_store(32'h248, 32'd5,          "R3 and");
        expect_store(32'h24C, 32'd7,          "R3 or");
        expect_store(32'h250, 32'd1,          "R3 slt true");
        expect_store(32'h254, 32'd0,          "R3 slt false");
        expect_store(32'h258, 32'd7,          "R6 branch not taken");
        expect_store(32'h260, 32'd0,          "R8 overflow write suppressed");
        expect_store(32'h264, 32'h7FFF_FFFF,  "R10 retried add after return");

        repeat (3) @(negedge clk);
        check("R1 reset mem_addr", mem_addr, 32'h0);
        check("R1 reset mem_we", {31'd0, mem_we}, 32'h0);
        check("R1 reset saved pc", epc_o, 32'h0);
        check("R1 reset reason", cause_o, 32'h0);
        rst_n = 1'b1;

        while (cause_o !== 32'h30) @(negedge clk);
        check("R8 vector fetch", mem_addr, 32'h8000_0180);
        check("R8 saved pc", epc_o, 32'h58);
        check("R8 reason", cause_o, 32'h30);

        while (cause_o !== 32'h28) @(negedge clk);
        check("R9 vector fetch", mem_addr, 32'h8000_0180);
        check("R9 saved pc", epc_o, 32'h60);
        check("R7 R6 all stores seen, none pending", sb_q.size(), 32'd0);
        finish_run();
    end

endmodule